// File: doc/BRIEF.md
# Execution-State and Exception Controller

This block owns a 32-bit current status word and a saved status word. It decides which of three instruction-set states the core runs in: 32-bit native, 16-bit compressed or stack bytecode. It also works out the program counter that follows each instruction it is given. It decodes three control words. The first is a conditional switch into bytecode state that jumps to an address held in a register. The second is a conditional exchange that picks native or compressed state from the low address bit. The third is an exception return. Any other word simply advances the PC by the size of an instruction in the current state.

An interrupt request is taken in place of the instruction offered with it, unless interrupts are masked. On entry the block saves the status word, leaves bytecode and compressed state, masks further interrupts, enters the interrupt mode, writes a return address to the link register and jumps to a vector. The return word restores the saved status word, so the core resumes in whatever state it was interrupted from.

Instructions arrive on a valid/ready stream. Results leave on a second valid/ready stream that carries the next PC and an optional link-register write. A result is registered and appears one cycle after its instruction is accepted. The status word changes on that same edge. A stalled result holds every field stable until the consumer takes it. A new instruction is accepted only while the result slot is empty or is being drained in that cycle.

Top module: `esx_ctrl`

## Requirements
- R1: After reset the current status word is 0x00000013, the saved status word is 0, the state output is 0 and no result is valid.
- R2: The state output encodes the status bits: 0 is native (J=0, T=0), 1 is compressed (J=0, T=1) and 2 is bytecode (J=1, T=0). Here J is bit 24, T is bit 5, I is bit 7, the flags N, Z, C and V are bits 31..28 and the mode is bits 4..0. J and T are never both set.
- R3: A condition code in instruction bits 31..28 is evaluated against N, Z, C and V using the 16 standard codes. Code 1110 always passes and code 1111 never passes.
- R4: A bytecode switch has bits 27..4 equal to 0x12FFF2. When its condition passes, the block sets J, clears T and makes the next PC the register operand. When the condition fails, the status word is unchanged and the PC advances.
- R5: Suppose irq is high when an instruction is accepted and I is 0. The instruction is then discarded. The saved word takes the current word. J and T are cleared, I is set and the mode becomes 10010, with the other bits kept. The link register is written with pc_cur + 4 and the next PC is IRQ_VEC. When I is 1, irq is ignored.
- R6: An exception return has bits 27..0 equal to 0x25EF004. When its condition passes, the next PC is lr_val - 4, the current word is restored from the saved word and the link register is not written.
- R7: An exchange has bits 27..4 equal to 0x12FFF1. When its condition passes, it clears J, sets T from bit 0 of the register operand and jumps to the operand with bit 0 cleared.
- R8: Any other word, and any failing control word, gives a next PC of pc_cur plus 4 in native state, 2 in compressed state or 1 in bytecode state, and leaves the status word unchanged.
- R9: An instruction is accepted when insn_valid and insn_ready are both high. insn_ready is low while a result is valid and not ready. A stalled result keeps its fields stable.
- R10: With flags_we high and no instruction accepted, flags_in loads bits 31..28. In a cycle where an instruction is accepted, flags_we is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction offered |
| insn_ready | output | 1 | Instruction can be accepted |
| insn | input | 32 | Instruction word |
| pc_cur | input | 32 | Address of the offered instruction |
| rm_val | input | 32 | Register operand value |
| lr_val | input | 32 | Current link-register value |
| irq | input | 1 | Interrupt request |
| flags_we | input | 1 | Load condition flags |
| flags_in | input | 4 | New N, Z, C, V |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_pc | output | 32 | Next program counter |
| res_lr_we | output | 1 | Link-register write enable |
| res_lr_data | output | 32 | Link-register write value |
| cpsr | output | 32 | Current status word |
| spsr | output | 32 | Saved status word |
| exec_state | output | 2 | Execution state code |

## Verification
Several properties are checked on every cycle. J and T are never set together. Interrupt entry saves the status word and forces the masked interrupt mode. A passing return restores the saved word, a passing switch jumps to the register operand, an always-code switch always enters bytecode state, and a stalled result holds still. Only the bench scenarios can show the rest. These cover the full sweep of 16 condition codes over all flag values, the PC step sizes in each state, an interrupt taken in bytecode state followed by a return into that state, a masked second interrupt, and a flag write ignored because it coincides with an accepted instruction, all under varying back-pressure.

// File: rtl/esx_pkg.sv
package esx_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned FLAG_HI = 31;
  localparam int unsigned FLAG_LO = 28;
  localparam int unsigned BIT_J = 24;
  localparam int unsigned BIT_I = 7;
  localparam int unsigned BIT_F = 6;
  localparam int unsigned BIT_T = 5;
  localparam int unsigned MODE_W = 5;

  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;

  localparam logic [23:0] SIG_TO_BYTE = 24'h12FFF2;
  localparam logic [23:0] SIG_XCHG    = 24'h12FFF1;
  localparam logic [27:0] SIG_RETURN  = 28'h25EF004;

  localparam logic [XLEN-1:0] STEP_NATIVE = 32'd4;
  localparam logic [XLEN-1:0] STEP_COMP   = 32'd2;
  localparam logic [XLEN-1:0] STEP_BYTE   = 32'd1;
  localparam logic [XLEN-1:0] LR_OFFSET   = 32'd4;

  typedef enum logic [1:0] {
    ST_NATIVE = 2'd0,
    ST_COMP   = 2'd1,
    ST_BYTE   = 2'd2,
    ST_ILLEG  = 2'd3
  } exec_state_e;

  typedef enum logic [1:0] {
    OP_SEQ  = 2'd0,
    OP_SWJ  = 2'd1,
    OP_SWX  = 2'd2,
    OP_RET  = 2'd3
  } op_e;

  typedef struct packed {
    logic [XLEN-1:0] pc;
    logic            lr_we;
    logic [XLEN-1:0] lr;
  } result_t;
endpackage

// File: rtl/esx_cond.sv
module esx_cond (
  input  logic [3:0] code,
  input  logic [3:0] nzcv,
  output logic       pass
);
  logic n, z, c, v;
  logic base;

  assign n = nzcv[3];
  assign z = nzcv[2];
  assign c = nzcv[1];
  assign v = nzcv[0];

  // even codes test a predicate, odd codes negate it (except 1110/1111)
  always_comb begin
    unique case (code[3:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c & ~z;
      3'd5: base = (n == v);
      3'd6: base = ~z & (n == v);
      default: base = 1'b1;
    endcase
    if (code == 4'hF)
      pass = 1'b0;
    else if (code == 4'hE)
      pass = 1'b1;
    else
      pass = code[0] ? ~base : base;
  end
endmodule

// File: rtl/esx_decode.sv
module esx_decode
  import esx_pkg::*;
(
  input  logic [27:0] body,
  output op_e         op
);
  always_comb begin
    if (body[27:4] == SIG_TO_BYTE)
      op = OP_SWJ;
    else if (body[27:4] == SIG_XCHG)
      op = OP_SWX;
    else if (body == SIG_RETURN)
      op = OP_RET;
    else
      op = OP_SEQ;
  end
endmodule

// File: rtl/esx_psr.sv
module esx_psr
  import esx_pkg::*;
#(
  parameter logic [MODE_W-1:0] RESET_MODE = MODE_SVC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic            take_irq,
  input  op_e             op,
  input  logic            pass,
  input  logic            rm_lsb,
  input  logic            flags_we,
  input  logic [3:0]      flags_in,
  output logic [XLEN-1:0] cpsr_q,
  output logic [XLEN-1:0] spsr_q
);
  localparam logic [XLEN-1:0] CPSR_RST = {{(XLEN-MODE_W){1'b0}}, RESET_MODE};

  logic [XLEN-1:0] cpsr_n, spsr_n;

  always_comb begin
    cpsr_n = cpsr_q;
    spsr_n = spsr_q;
    if (acc) begin
      if (take_irq) begin
        spsr_n = cpsr_q;
        cpsr_n[BIT_J] = 1'b0;
        cpsr_n[BIT_T] = 1'b0;
        cpsr_n[BIT_I] = 1'b1;
        cpsr_n[MODE_W-1:0] = MODE_IRQ;
      end else if (pass) begin
        unique case (op)
          OP_SWJ: begin
            cpsr_n[BIT_J] = 1'b1;
            cpsr_n[BIT_T] = 1'b0;
          end
          OP_SWX: begin
            cpsr_n[BIT_J] = 1'b0;
            cpsr_n[BIT_T] = rm_lsb;
          end
          OP_RET: cpsr_n = spsr_q;
          default: ;
        endcase
      end
    end else if (flags_we) begin
      cpsr_n[FLAG_HI:FLAG_LO] = flags_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpsr_q <= CPSR_RST;
      spsr_q <= '0;
    end else begin
      cpsr_q <= cpsr_n;
      spsr_q <= spsr_n;
    end
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpsr_q[BIT_J] && cpsr_q[BIT_T])); // R2

  AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && take_irq) |=> (spsr_q == $past(cpsr_q))); // R5

  AST_ENTRY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && take_irq) |=> (cpsr_q[BIT_I] && !cpsr_q[BIT_J] && !cpsr_q[BIT_T]
                           && cpsr_q[MODE_W-1:0] == MODE_IRQ)); // R5

  AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !take_irq && pass && op == OP_RET) |=> (cpsr_q == $past(spsr_q))); // R6

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && flags_we) |=> (cpsr_q[FLAG_HI:FLAG_LO] == $past(flags_in))); // R10
endmodule

// File: rtl/esx_ctrl.sv
module esx_ctrl
  import esx_pkg::*;
#(
  parameter logic [XLEN-1:0]   IRQ_VEC    = 32'h0000_0018,
  parameter logic [MODE_W-1:0] RESET_MODE = MODE_SVC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  output logic            insn_ready,
  input  logic [XLEN-1:0] insn,
  input  logic [XLEN-1:0] pc_cur,
  input  logic [XLEN-1:0] rm_val,
  input  logic [XLEN-1:0] lr_val,
  input  logic            irq,
  input  logic            flags_we,
  input  logic [3:0]      flags_in,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [XLEN-1:0] res_pc,
  output logic            res_lr_we,
  output logic [XLEN-1:0] res_lr_data,
  output logic [XLEN-1:0] cpsr,
  output logic [XLEN-1:0] spsr,
  output logic [1:0]      exec_state
);
  op_e             op;
  logic            pass;
  logic            acc;
  logic            take_irq;
  logic [XLEN-1:0] step;
  exec_state_e     st;
  result_t         nxt, res_q;

  esx_decode u_dec (
    .body (insn[27:0]),
    .op   (op)
  );

  esx_cond u_cond (
    .code (insn[31:28]),
    .nzcv (cpsr[FLAG_HI:FLAG_LO]),
    .pass (pass)
  );

  esx_psr #(.RESET_MODE(RESET_MODE)) u_psr (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .take_irq (take_irq),
    .op       (op),
    .pass     (pass),
    .rm_lsb   (rm_val[0]),
    .flags_we (flags_we),
    .flags_in (flags_in),
    .cpsr_q   (cpsr),
    .spsr_q   (spsr)
  );

  assign insn_ready = !res_valid || res_ready;
  assign acc        = insn_valid && insn_ready;
  assign take_irq   = irq && !cpsr[BIT_I];

  always_comb begin
    unique case ({cpsr[BIT_J], cpsr[BIT_T]})
      2'b00:   st = ST_NATIVE;
      2'b01:   st = ST_COMP;
      2'b10:   st = ST_BYTE;
      default: st = ST_ILLEG;
    endcase
  end
  assign exec_state = st;

  always_comb begin
    unique case (st)
      ST_COMP: step = STEP_COMP;
      ST_BYTE: step = STEP_BYTE;
      default: step = STEP_NATIVE;
    endcase
  end

  always_comb begin
    nxt.pc    = pc_cur + step;
    nxt.lr_we = 1'b0;
    nxt.lr    = '0;
    if (take_irq) begin
      nxt.pc    = IRQ_VEC;
      nxt.lr_we = 1'b1;
      nxt.lr    = pc_cur + LR_OFFSET;
    end else if (pass) begin
      unique case (op)
        OP_SWJ:  nxt.pc = rm_val;
        OP_SWX:  nxt.pc = {rm_val[XLEN-1:1], 1'b0};
        OP_RET:  nxt.pc = lr_val - LR_OFFSET;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_q     <= '0;
    end else if (acc) begin
      res_valid <= 1'b1;
      res_q     <= nxt;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assign res_pc      = res_q.pc;
  assign res_lr_we   = res_q.lr_we;
  assign res_lr_data = res_q.lr;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_pc)
                                   && $stable(res_lr_we) && $stable(res_lr_data))); // R9

  AST_SWITCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !take_irq && pass && op == OP_SWJ) |=> (res_pc == $past(rm_val)
                                                    && exec_state == 2'd2)); // R4

  AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !take_irq && insn[31:28] == 4'hE && op == OP_SWJ) |=> cpsr[BIT_J]); // R3

  AST_RETURN_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !take_irq && pass && op == OP_RET) |=> (res_pc == $past(lr_val) - LR_OFFSET
                                                    && !res_lr_we)); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cpsr[BIT_I]) |=> !res_lr_we); // R5
endmodule

// File: tb/sim_esx_ctrl.sv
`timescale 1ns/1ps
module sim_esx_ctrl;
  localparam logic [31:0] VEC = 32'h0000_0018;

  typedef struct packed {
    logic [31:0] pc;
    logic        lr_we;
    logic [31:0] lr;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic        insn_ready;
  logic [31:0] insn = '0;
  logic [31:0] pc_cur = '0;
  logic [31:0] rm_val = '0;
  logic [31:0] lr_val = '0;
  logic        irq = 1'b0;
  logic        flags_we = 1'b0;
  logic [3:0]  flags_in = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_pc;
  logic        res_lr_we;
  logic [31:0] res_lr_data;
  logic [31:0] cpsr;
  logic [31:0] spsr;
  logic [1:0]  exec_state;

  int errors = 0;
  int checks = 0;
  bit bp = 1'b0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] m_cpsr, m_spsr, m_pc;
  exp_t  q_exp[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  esx_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
    .insn(insn), .pc_cur(pc_cur), .rm_val(rm_val), .lr_val(lr_val), .irq(irq),
    .flags_we(flags_we), .flags_in(flags_in), .res_valid(res_valid),
    .res_ready(res_ready), .res_pc(res_pc), .res_lr_we(res_lr_we),
    .res_lr_data(res_lr_data), .cpsr(cpsr), .spsr(spsr), .exec_state(exec_state)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit cond_ok(input logic [3:0] code, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (code)
      4'h0: return z;
      4'h1: return !z;
      4'h2: return c;
      4'h3: return !c;
      4'h4: return n;
      4'h5: return !n;
      4'h6: return v;
      4'h7: return !v;
      4'h8: return c && !z;
      4'h9: return !c || z;
      4'hA: return n == v;
      4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] m_state(input logic [31:0] p);
    return p[24] ? 2'd2 : (p[5] ? 2'd1 : 2'd0);
  endfunction

  task automatic check_status(input string req);
    chk(cpsr == m_cpsr, req, "cpsr", cpsr, m_cpsr);
    chk(spsr == m_spsr, req, "spsr", spsr, m_spsr);
    chk(exec_state == m_state(m_cpsr), "R2", "state", 32'(exec_state), 32'(m_state(m_cpsr)));
  endtask

  task automatic send(input logic [31:0] w, input logic [31:0] rm, input logic [31:0] lr,
                      input bit irq_i, input bit fw, input logic [3:0] fin, input string req);
    exp_t e;
    bit   ti, ps;
    logic [31:0] step;
    @(negedge clk);
    insn = w; rm_val = rm; lr_val = lr; pc_cur = m_pc; irq = irq_i;
    flags_we = fw; flags_in = fin; insn_valid = 1'b1;
    #1;
    while (!insn_ready) begin
      @(negedge clk);
      #1;
    end
    step = (m_state(m_cpsr) == 2'd2) ? 32'd1 : (m_state(m_cpsr) == 2'd1 ? 32'd2 : 32'd4);
    ti = irq_i && !m_cpsr[7];
    e.pc = m_pc + step; e.lr_we = 1'b0; e.lr = '0;
    if (ti) begin
      e.pc = VEC; e.lr_we = 1'b1; e.lr = m_pc + 32'd4;
      m_spsr = m_cpsr;
      m_cpsr[24] = 1'b0; m_cpsr[5] = 1'b0; m_cpsr[7] = 1'b1; m_cpsr[4:0] = 5'b10010;
    end else begin
      ps = cond_ok(w[31:28], m_cpsr[31:28]);
      if (ps && w[27:4] == 24'h12FFF2) begin
        e.pc = rm; m_cpsr[24] = 1'b1; m_cpsr[5] = 1'b0;
      end else if (ps && w[27:4] == 24'h12FFF1) begin
        e.pc = {rm[31:1], 1'b0}; m_cpsr[24] = 1'b0; m_cpsr[5] = rm[0];
      end else if (ps && w[27:0] == 28'h25EF004) begin
        e.pc = lr - 32'd4; m_cpsr = m_spsr;
      end
    end
    q_exp.push_back(e);
    q_tag.push_back(req);
    m_pc = e.pc;
    @(negedge clk);
    insn_valid = 1'b0; irq = 1'b0; flags_we = 1'b0;
    #1;
    check_status(req);
  endtask

  task automatic set_flags(input logic [3:0] f);
    @(negedge clk);
    flags_we = 1'b1; flags_in = f;
    @(negedge clk);
    flags_we = 1'b0;
    #1;
    m_cpsr[31:28] = f;
    chk(cpsr[31:28] == f, "R10", "flag load", 32'(cpsr[31:28]), 32'(f));
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    res_ready = bp ? (cyc % 3 == 0) : 1'b1;
  end

  // monitor: pops expected results as the design hands them over
  always begin
    @(negedge clk);
    #2;
    if (rst_n && res_valid && !res_ready)
      chk(!insn_ready, "R9", "ready while stalled", 32'(insn_ready), 32'd0);
    if (rst_n && res_valid && res_ready) begin
      if (q_exp.size() == 0) begin
        chk(1'b0, "R9", "unexpected result", res_pc, 32'd0);
      end else begin
        exp_t  e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(res_pc == e.pc, t, "next pc", res_pc, e.pc);
        chk(res_lr_we == e.lr_we, t, "lr write", 32'(res_lr_we), 32'(e.lr_we));
        if (e.lr_we)
          chk(res_lr_data == e.lr, t, "lr data", res_lr_data, e.lr);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R9", "watchdog expired", 32'(cyc), 32'd0);
      finish_run();
    end
  end

  initial begin
    m_cpsr = 32'h0000_0013; m_spsr = '0; m_pc = 32'h0000_1000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(cpsr == 32'h13, "R1", "reset cpsr", cpsr, 32'h13);
    chk(spsr == 32'h0, "R1", "reset spsr", spsr, 32'h0);
    chk(exec_state == 2'd0, "R1", "reset state", 32'(exec_state), 32'd0);
    chk(!res_valid, "R1", "reset valid", 32'(res_valid), 32'd0);

    set_flags(4'b0100);                                          // Z set
    send({4'h0, 24'h12FFF2, 4'h3}, 32'h2000, 0, 0, 0, 0, "R4");  // EQ passes
    send(32'hE1A0_0000, 0, 0, 0, 0, 0, "R8");                    // step 1 in bytecode
    send(32'hE1A0_0000, 0, 0, 1, 0, 0, "R5");                    // irq from bytecode
    send(32'hE1A0_0000, 0, 0, 1, 0, 0, "R5");                    // masked irq ignored
    send({4'hE, 28'h25EF004}, 0, 32'h2005, 0, 0, 0, "R6");      // return to bytecode
    chk(exec_state == 2'd2, "R6", "back in bytecode", 32'(exec_state), 32'd2);
    send({4'h1, 24'h12FFF2, 4'h3}, 32'h5000, 0, 0, 0, 0, "R4");  // NE fails
    send({4'hE, 24'h12FFF1, 4'h2}, 32'h3001, 0, 0, 0, 0, "R7");  // to compressed
    send(32'hE1A0_0000, 0, 0, 0, 0, 0, "R8");                    // step 2
    send(32'hE1A0_0000, 0, 0, 0, 1, 4'hF, "R10");                // flag write ignored
    chk(cpsr[31:28] == 4'b0100, "R10", "flags kept", 32'(cpsr[31:28]), 32'h4);
    send({4'hE, 24'h12FFF1, 4'h2}, 32'h4000, 0, 0, 0, 0, "R7");  // to native
    send(32'hE1A0_0000, 0, 0, 0, 0, 0, "R8");                    // step 4

    bp = 1'b1;
    for (int f = 0; f < 16; f++) begin
      set_flags(4'(f));
      for (int c = 0; c < 16; c++)
        send({4'(c), 24'h12FFF1, 4'h1}, 32'h4000 + 32'(c << 4), 0, 0, 0, 0, "R3");
    end
    bp = 1'b0;
    repeat (10) @(negedge clk);
    chk(q_exp.size() == 0, "R9", "results drained", 32'(q_exp.size()), 32'd0);
    done = 1'b1;
    finish_run();
  end
endmodule